// File: doc/BRIEF.md
# Mixed-Page-Size Translation Lookaside Buffer

This block is a small fully associative translation cache in which every slot may map a page of a different size. A slot holds a virtual page tag, a physical frame base, a valid bit and an offset mask. The mask is derived from a two-bit size code given when the slot is filled. For each slot, the mask selects which low address bits are page offset and pass straight through. The remaining upper bits must match the tag and are replaced by the frame base. Standard 4 KiB pages and huge pages of 2 MiB and 1 GiB live side by side in the same array.

Lookup is purely combinational. A 48-bit virtual address goes in, and a hit flag, a 40-bit physical address and a multiple-match flag come out in the same cycle.

A fill port writes one slot on the next clock edge. It places the new mapping in the lowest-numbered invalid slot. When every slot is valid, it overwrites the slot named by a round-robin pointer and then advances that pointer. An invalidate port can clear every slot whose page contains a given address, or clear the whole array in one cycle.

Top module: `mpage_tlb`

## Requirements
- R1: After reset every slot is invalid and the round-robin pointer is 0. Any lookup then returns `lk_hit`=0, `lk_multi`=0 and `lk_paddr`=0.
- R2: Size code 2'b00 maps a 4 KiB page. Virtual bits 47:12 must equal the tag. The physical address is frame bits 39:12 joined with virtual bits 11:0.
- R3: Size code 2'b01 maps a 2 MiB page. Virtual bits 47:21 are compared, and virtual bits 20:0 pass through as offset.
- R4: Size code 2'b10 maps a 1 GiB page. Virtual bits 47:30 are compared, and virtual bits 29:0 pass through as offset.
- R5: On a fill, tag and frame bits below the page size are stored as zero. A misaligned fill therefore maps the naturally aligned page that contains the given address.
- R6: A fill with size code 2'b11 is ignored. No slot changes and the round-robin pointer does not move.
- R7: When several valid slots match, the lowest-numbered slot supplies the physical address and `lk_multi` is 1 in that cycle.
- R8: When no valid slot matches, `lk_hit` is 0 and `lk_paddr` is 0.
- R9: A fill goes to the lowest-numbered invalid slot whenever one exists.
- R10: When all 16 slots are valid, a fill overwrites the slot at the round-robin pointer. The pointer then advances by one and wraps from 15 to 0. Fills into a free slot leave the pointer unchanged.
- R11: With `inv_en` set, every valid slot whose page contains `inv_vaddr` becomes invalid at the next edge. A fill in the same cycle picks its slot from the valid bits as they were before the invalidation, and its write takes effect.
- R12: `inv_all` clears every slot at the next edge and overrides any fill or address invalidation in the same cycle.
- R13: Lookup is combinational. A fill becomes visible to lookups only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_hit | output | 1 | A valid slot covers lk_vaddr |
| lk_multi | output | 1 | More than one valid slot covers lk_vaddr |
| lk_paddr | output | 40 | Translated physical address, 0 on miss |
| fill_en | input | 1 | Write a new mapping at the next edge |
| fill_vaddr | input | 48 | Virtual address inside the page to map |
| fill_paddr | input | 40 | Physical address inside the target frame |
| fill_size | input | 2 | Page size code: 00 4 KiB, 01 2 MiB, 10 1 GiB, 11 ignored |
| inv_en | input | 1 | Invalidate slots covering inv_vaddr |
| inv_vaddr | input | 48 | Address for selective invalidation |
| inv_all | input | 1 | Clear every slot |

## Verification
The bench targets the three page boundaries, using the last byte inside a page and the first byte beyond it. A design that compares the wrong number of bits for a size either misses inside the page or hits past it.

It fills misaligned addresses to catch a design that keeps the low tag or frame bits. Such a design would miss on the aligned start of the page or corrupt the offset.

Overlapping small and huge mappings are placed in both slot orders. A wrong priority encoder returns the wrong frame or leaves the multiple-match flag low. The bench also fills beyond capacity to expose a pointer that advances on free-slot fills or fails to wrap.

Finally, it mixes fills with address invalidation, full flushes and reserved size codes in the same cycle. This catches a design that applies them in the wrong order or lets a reserved fill consume a slot.

// File: rtl/mpage_tlb.sv
module mpage_tlb #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] lk_vaddr,
  output logic            lk_hit,
  output logic            lk_multi,
  output logic [PA_W-1:0] lk_paddr,
  input  logic            fill_en,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic [PA_W-1:0] fill_paddr,
  input  logic [1:0]      fill_size,
  input  logic            inv_en,
  input  logic [VA_W-1:0] inv_vaddr,
  input  logic            inv_all
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int OFF_SM = 12;
  localparam int OFF_MD = 21;
  localparam int OFF_LG = 30;

  logic [ENTRIES-1:0] vld;
  logic [VA_W-1:0]    tag [ENTRIES];
  logic [PA_W-1:0]    frm [ENTRIES];
  logic [VA_W-1:0]    msk [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [ENTRIES-1:0] lk_match, inv_match;
  logic [IDX_W-1:0]   sel, vict;
  logic               has_free, fill_ok;
  logic [VA_W-1:0]    fmask;

  always_comb begin
    case (fill_size)
      2'b00:   fmask = (VA_W'(1) << OFF_SM) - VA_W'(1);
      2'b01:   fmask = (VA_W'(1) << OFF_MD) - VA_W'(1);
      default: fmask = (VA_W'(1) << OFF_LG) - VA_W'(1);
    endcase
  end

  assign fill_ok = fill_en && (fill_size != 2'b11);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]  = vld[i] && ((lk_vaddr  & ~msk[i]) == tag[i]);
    assign inv_match[i] = vld[i] && ((inv_vaddr & ~msk[i]) == tag[i]);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_match[i]) sel = IDX_W'(i);
  end

  assign lk_hit   = |lk_match;
  assign lk_multi = (lk_match & (lk_match - 1'b1)) != '0;
  assign lk_paddr = lk_hit ? (frm[sel] | PA_W'(lk_vaddr & msk[sel])) : '0;

  always_comb begin
    vict     = rr;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        vict     = IDX_W'(i);
        has_free = 1'b1;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (inv_all) begin
      vld <= '0;
    end else begin
      if (inv_en) vld <= vld & ~inv_match;
      if (fill_ok) begin
        vld[vict] <= 1'b1;
        if (!has_free)
          rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok && !inv_all) begin
      tag[vict] <= fill_vaddr & ~fmask;
      frm[vict] <= fill_paddr & ~PA_W'(fmask);
      msk[vict] <= fmask;
    end
  end

  assert_multi_implies_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);

  assert_small_offset_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_SM-1:0] == lk_vaddr[OFF_SM-1:0]));

  assert_flush_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0));

  assert_reserved_fill_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_size == 2'b11 && !inv_en && !inv_all) |=> ($stable(vld) && $stable(rr)));

  assert_pointer_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> $stable(rr));
endmodule

// File: tb/tb_mpage_tlb.sv
module tb_mpage_tlb;
  localparam int CLK_NS = 10;
  localparam int N      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic        lk_hit, lk_multi;
  logic [39:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [47:0] fill_vaddr = '0;
  logic [39:0] fill_paddr = '0;
  logic [1:0]  fill_size = 2'b00;
  logic        inv_en = 1'b0;
  logic [47:0] inv_vaddr = '0;
  logic        inv_all = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  mpage_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_multi(lk_multi), .lk_paddr(lk_paddr), .fill_en(fill_en),
    .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr), .fill_size(fill_size),
    .inv_en(inv_en), .inv_vaddr(inv_vaddr), .inv_all(inv_all)
  );

  int vectors = 0;
  int errs = 0;
  bit          mv  [N];
  logic [47:0] mva [N];
  logic [39:0] mpa [N];
  int          msz [N];
  int          mrr = 0;

  function automatic int offb(int s);
    return (s == 0) ? 12 : (s == 1) ? 21 : 30;
  endfunction

  function automatic bit covers(int i, logic [47:0] a);
    int ob = offb(msz[i]);
    return mv[i] && ((a >> ob) == (mva[i] >> ob));
  endfunction

  task automatic check(string tag);
    bit exp_hit = 0;
    bit exp_multi = 0;
    logic [39:0] exp_pa = '0;
    for (int i = 0; i < N; i++) begin
      if (covers(i, lk_vaddr)) begin
        if (exp_hit) exp_multi = 1;
        else begin
          int ob = offb(msz[i]);
          exp_hit = 1;
          exp_pa = ((mpa[i] >> ob) << ob) | 40'(lk_vaddr & ((48'd1 << ob) - 48'd1));
        end
      end
    end
    vectors++;
    if (lk_hit !== exp_hit || lk_multi !== exp_multi || lk_paddr !== exp_pa) begin
      errs++;
      $display("FAIL %s va=%h: hit/multi/pa got %b/%b/%h expected %b/%b/%h",
               tag, lk_vaddr, lk_hit, lk_multi, lk_paddr, exp_hit, exp_multi, exp_pa);
    end
  endtask

  task automatic model_edge();
    int v = -1;
    for (int i = 0; i < N; i++) if (!mv[i] && v < 0) v = i;
    if (inv_all) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
      return;
    end
    if (inv_en)
      for (int i = 0; i < N; i++) if (covers(i, inv_vaddr)) mv[i] = 0;
    if (fill_en && fill_size != 2'b11) begin
      if (v < 0) begin
        v = mrr;
        mrr = (mrr + 1) % N;
      end
      mv[v] = 1; mva[v] = fill_vaddr; mpa[v] = fill_paddr; msz[v] = int'(fill_size);
    end
  endtask

  task automatic tick(string tag);
    #1 check(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    fill_en = 0; inv_en = 0; inv_all = 0;
  endtask

  task automatic look(logic [47:0] a, string tag);
    lk_vaddr = a;
    tick(tag);
  endtask

  task automatic fill(logic [47:0] va, logic [39:0] pa, logic [1:0] sz, string tag);
    fill_en = 1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
    lk_vaddr = va;
    tick(tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(48'h0000_1234_5678, "R1");
    look(48'h0000_0000_0000, "R8");

    fill(48'h0000_1234_5000, 40'h00_ABCD_E000, 2'b00, "R13");
    look(48'h0000_1234_5FFF, "R2");
    look(48'h0000_1234_6000, "R2");
    look(48'h0000_1234_4FFF, "R8");

    fill(48'h0000_4020_0000, 40'h12_3440_0000, 2'b01, "R13");
    look(48'h0000_403F_FFFF, "R3");
    look(48'h0000_4040_0000, "R3");

    fill(48'h0080_4000_0000, 40'h80_4000_0000, 2'b10, "R13");
    look(48'h0080_7FFF_FFFF, "R4");
    look(48'h0080_8000_0000, "R4");

    fill(48'h0000_6000_1234, 40'h00_2000_5678, 2'b01, "R5");
    look(48'h0000_6000_0000, "R5");
    look(48'h0000_601F_FFFF, "R5");

    fill(48'h0000_7000_0000, 40'h00_1111_0000, 2'b11, "R6");
    look(48'h0000_7000_0000, "R6");

    fill(48'h0000_4020_3000, 40'h55_0000_0000, 2'b00, "R9");
    look(48'h0000_4020_3ABC, "R7");
    inv_en = 1; inv_vaddr = 48'h0000_4020_3000; lk_vaddr = 48'h0000_4020_3ABC;
    tick("R11");
    look(48'h0000_4020_3ABC, "R11");
    look(48'h0000_4030_0000, "R11");
    fill(48'h0000_4020_3000, 40'h55_0000_0000, 2'b00, "R9");
    fill(48'h0000_4020_0000, 40'h12_3440_0000, 2'b01, "R9");
    look(48'h0000_4020_3ABC, "R7");
    look(48'h0000_4021_0000, "R7");

    for (int k = 0; k < 20; k++)
      fill(48'h0001_0000_0000 + 48'(k) * 48'h1000, 40'h01_0000_0000 + 40'(k) * 40'h1000,
           2'b00, "R10");
    look(48'h0000_1234_5000, "R10");
    look(48'h0001_0000_2000, "R10");
    look(48'h0001_0001_3000, "R10");

    inv_en = 1; inv_vaddr = 48'h0001_0000_5000;
    fill_en = 1; fill_vaddr = 48'h0002_0000_0000; fill_paddr = 40'h02_0000_0000; fill_size = 2'b00;
    tick("R11");
    look(48'h0001_0000_5000, "R11");
    look(48'h0002_0000_0ABC, "R11");

    inv_all = 1;
    fill_en = 1; fill_vaddr = 48'h0003_0000_0000; fill_paddr = 40'h03_0000_0000; fill_size = 2'b10;
    tick("R12");
    look(48'h0003_0000_0000, "R12");
    look(48'h0002_0000_0ABC, "R12");

    for (int n = 0; n < 600; n++) begin
      logic [47:0] a;
      a = (48'($urandom % 4) << 30) | (48'($urandom % 8) << 21) |
          (48'($urandom % 4) << 12) | 48'($urandom % 4096);
      if ($urandom % 2 == 0) begin
        fill_en = 1;
        fill_vaddr = a;
        fill_paddr = 40'({$urandom, $urandom});
        fill_size = 2'($urandom % 4);
      end
      if ($urandom % 10 == 0) begin
        inv_en = 1;
        inv_vaddr = a ^ 48'($urandom % 8192);
      end
      if ($urandom % 60 == 0) inv_all = 1;
      lk_vaddr = (48'($urandom % 4) << 30) | (48'($urandom % 8) << 21) |
                 (48'($urandom % 4) << 12) | 48'($urandom % 4096);
      tick("R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule